// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand in two steps. It first builds an effective offset from up to three terms: a base register value, an index register value that can be multiplied by 1, 2, 4 or 8, and a displacement. Each term has its own enable. It then looks up a segment descriptor chosen by a selector. It checks the offset against that descriptor's limit and access type, and adds the descriptor's base to produce a linear address.

The descriptor table is a small bank of registers, loaded one entry per cycle through a write port. Each entry holds a base, a limit and a two-bit type: bit 0 means present and bit 1 means writable. A request is accepted on any cycle in which the request strobe is high. Its result appears one clock later, either as a valid linear address or as a fault.

Top module: `eag_top`

## Requirements
- R1: The offset is the sum of the base term, the scaled index term and the displacement. A term whose enable is low contributes zero.
- R2: The scale code multiplies only the index term: code 0 by 1, code 1 by 2, code 2 by 4, code 3 by 8.
- R3: The offset sum wraps modulo 2^OFS_W, and any carry out of the top bit is dropped.
- R4: The linear address is the selected descriptor's base plus the offset, taken modulo 2^BASE_W.
- R5: An offset strictly greater than the selected limit gives a fault and no valid strobe. An offset equal to the limit is accepted.
- R6: A request to a descriptor whose type bit 0 (present) is clear gives a fault, for reads and writes alike.
- R7: A write request (access-write input high) to a descriptor whose type bit 1 (writable) is clear gives a fault. A read of the same descriptor is accepted.
- R8: The valid or fault output rises exactly one clock after a request strobe. Requests on back-to-back cycles each get their own result. A cycle without a request gives both outputs low and an address of zero on the next cycle.
- R9: The valid and fault outputs are never high together, and the address output is zero whenever fault is high.
- R10: Reset clears the outputs. It also sets every descriptor to base zero, limit all ones and type 2'b11 (present and writable).
- R11: A descriptor write is seen by requests from the next cycle on. A request in the same cycle as a write to its own entry uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write access |
| base_en | input | 1 | Include base term |
| base_val | input | OFS_W | Base register value |
| idx_en | input | 1 | Include index term |
| idx_val | input | OFS_W | Index register value |
| idx_scale | input | 2 | Index scale code (0:x1, 1:x2, 2:x4, 3:x8) |
| disp_en | input | 1 | Include displacement |
| disp_val | input | OFS_W | Displacement |
| seg_sel | input | SEL_W | Descriptor selector |
| dt_we | input | 1 | Descriptor table write enable |
| dt_addr | input | SEL_W | Descriptor entry to write |
| dt_base | input | BASE_W | New entry base |
| dt_limit | input | OFS_W | New entry limit |
| dt_type | input | 2 | New entry type (bit 0 present, bit 1 writable) |
| out_valid | output | 1 | Linear address is valid |
| out_fault | output | 1 | Limit or type violation |
| out_addr | output | BASE_W | Linear address |

## Verification
Every result of this block is due on the first rising edge after its request, because a single output register sits behind the combinational offset, lookup and check paths. Table writes take effect at the same edge. The bench drives each request and each table write on a falling edge and lets one rising edge pass. It compares all three outputs just after that edge, using a bench-side copy of the table taken before the write in that cycle. Idle cycles are checked the same way, so a missing or stale strobe shows up in the cycle where it occurs.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int TYPE_W   = 2;
    localparam int PRES_BIT = 0;
    localparam int WR_BIT   = 1;

    typedef enum logic [1:0] {
        SC_X1 = 2'd0,
        SC_X2 = 2'd1,
        SC_X4 = 2'd2,
        SC_X8 = 2'd3
    } scale_e;

    typedef logic [TYPE_W-1:0] seg_type_t;
endpackage

// File: rtl/eag_offset.sv
module eag_offset #(
    parameter int OFS_W = 32
) (
    input  logic             base_en,
    input  logic [OFS_W-1:0] base_val,
    input  logic             idx_en,
    input  logic [OFS_W-1:0] idx_val,
    input  logic [1:0]       idx_scale,
    input  logic             disp_en,
    input  logic [OFS_W-1:0] disp_val,
    output logic [OFS_W-1:0] offset
);
    import eag_pkg::*;

    logic [OFS_W-1:0] base_term, idx_term, disp_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        disp_term = disp_en ? disp_val : '0;
        idx_term  = '0;
        if (idx_en) begin
            unique case (scale_e'(idx_scale))
                SC_X1: idx_term = idx_val;
                SC_X2: idx_term = idx_val << 1;
                SC_X4: idx_term = idx_val << 2;
                SC_X8: idx_term = idx_val << 3;
                default: idx_term = idx_val;
            endcase
        end
        // carries beyond OFS_W are dropped by the assignment width
        offset = base_term + idx_term + disp_term;
    end
endmodule

// File: rtl/eag_desc_table.sv
module eag_desc_table #(
    parameter int NSEG   = 8,
    parameter int BASE_W = 32,
    parameter int OFS_W  = 32,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     waddr,
    input  logic [BASE_W-1:0]    wbase,
    input  logic [OFS_W-1:0]     wlimit,
    input  eag_pkg::seg_type_t   wtype,
    input  logic [SEL_W-1:0]     raddr,
    output logic [BASE_W-1:0]    rbase,
    output logic [OFS_W-1:0]     rlimit,
    output eag_pkg::seg_type_t   rtype
);
    import eag_pkg::*;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [OFS_W-1:0]  limit;
        seg_type_t         kind;
    } desc_t;

    desc_t ent_q [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        desc_t ent_d;

        always_comb begin
            ent_d = ent_q[g];
            if (we && (waddr == SEL_W'(g))) begin
                ent_d.base  = wbase;
                ent_d.limit = wlimit;
                ent_d.kind  = wtype;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g].base  <= '0;
                ent_q[g].limit <= '1;
                ent_q[g].kind  <= 2'b11;
            end else begin
                ent_q[g] <= ent_d;
            end
        end

        // R11: a write lands in exactly the addressed entry
        a_r11_entry_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == SEL_W'(g)) |=> (ent_q[g].base == $past(wbase)
                && ent_q[g].limit == $past(wlimit) && ent_q[g].kind == $past(wtype)));

        // R11: other entries keep their contents
        a_r11_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == SEL_W'(g)) |=> $stable(ent_q[g]));
    end

    always_comb begin
        rbase  = ent_q[raddr].base;
        rlimit = ent_q[raddr].limit;
        rtype  = ent_q[raddr].kind;
    end
endmodule

// File: rtl/eag_check.sv
module eag_check #(
    parameter int OFS_W = 32
) (
    input  logic               is_write,
    input  logic [OFS_W-1:0]   offset,
    input  logic [OFS_W-1:0]   limit,
    input  eag_pkg::seg_type_t kind,
    output logic               fault
);
    import eag_pkg::*;

    logic over_limit, not_present, write_denied;

    always_comb begin
        over_limit   = offset > limit;
        not_present  = !kind[PRES_BIT];
        write_denied = is_write && !kind[WR_BIT];
        fault        = over_limit || not_present || write_denied;
    end
endmodule

// File: rtl/eag_top.sv
module eag_top #(
    parameter int NSEG   = 8,
    parameter int BASE_W = 32,
    parameter int OFS_W  = 32,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              base_en,
    input  logic [OFS_W-1:0]  base_val,
    input  logic              idx_en,
    input  logic [OFS_W-1:0]  idx_val,
    input  logic [1:0]        idx_scale,
    input  logic              disp_en,
    input  logic [OFS_W-1:0]  disp_val,
    input  logic [SEL_W-1:0]  seg_sel,
    input  logic              dt_we,
    input  logic [SEL_W-1:0]  dt_addr,
    input  logic [BASE_W-1:0] dt_base,
    input  logic [OFS_W-1:0]  dt_limit,
    input  logic [1:0]        dt_type,
    output logic              out_valid,
    output logic              out_fault,
    output logic [BASE_W-1:0] out_addr
);
    import eag_pkg::*;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [BASE_W-1:0] addr;
    } res_t;

    res_t res_d, res_q;

    logic [OFS_W-1:0]  offset;
    logic [BASE_W-1:0] seg_base;
    logic [OFS_W-1:0]  seg_limit;
    seg_type_t         seg_kind;
    logic              fault;

    eag_offset #(.OFS_W(OFS_W)) u_ofs (
        .base_en  (base_en),
        .base_val (base_val),
        .idx_en   (idx_en),
        .idx_val  (idx_val),
        .idx_scale(idx_scale),
        .disp_en  (disp_en),
        .disp_val (disp_val),
        .offset   (offset)
    );

    eag_desc_table #(.NSEG(NSEG), .BASE_W(BASE_W), .OFS_W(OFS_W)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dt_we),
        .waddr (dt_addr),
        .wbase (dt_base),
        .wlimit(dt_limit),
        .wtype (dt_type),
        .raddr (seg_sel),
        .rbase (seg_base),
        .rlimit(seg_limit),
        .rtype (seg_kind)
    );

    eag_check #(.OFS_W(OFS_W)) u_chk (
        .is_write(req_write),
        .offset  (offset),
        .limit   (seg_limit),
        .kind    (seg_kind),
        .fault   (fault)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            if (fault) begin
                res_d.fault = 1'b1;
            end else begin
                res_d.valid = 1'b1;
                res_d.addr  = seg_base + BASE_W'(offset);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_fault = res_q.fault;
    assign out_addr  = res_q.addr;

    // R9: outcome is exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    // R9: no address leaks on a fault
    a_r9_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_addr == '0));

    // R8: every request gets a result one clock later
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid || out_fault));

    // R8: no request, no result
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !out_fault && out_addr == '0));

    // R5: an offset past the limit always faults
    a_r5_over_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && offset > seg_limit) |=> out_fault);

    // R6: a non-present descriptor always faults
    a_r6_not_present: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_kind[PRES_BIT]) |=> out_fault);
endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 8;
    localparam int BW = 32;
    localparam int OW = 32;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, base_en = 0, idx_en = 0, disp_en = 0;
    logic [OW-1:0] base_val = '0, idx_val = '0, disp_val = '0;
    logic [1:0] idx_scale = '0;
    logic [SW-1:0] seg_sel = '0, dt_addr = '0;
    logic dt_we = 0;
    logic [BW-1:0] dt_base = '0;
    logic [OW-1:0] dt_limit = '0;
    logic [1:0] dt_type = '0;
    logic out_valid, out_fault;
    logic [BW-1:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [BW-1:0] sh_base [NSEG];
    logic [OW-1:0] sh_lim  [NSEG];
    logic [1:0]    sh_type [NSEG];

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top #(.NSEG(NSEG), .BASE_W(BW), .OFS_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .base_en(base_en), .base_val(base_val), .idx_en(idx_en), .idx_val(idx_val),
        .idx_scale(idx_scale), .disp_en(disp_en), .disp_val(disp_val),
        .seg_sel(seg_sel), .dt_we(dt_we), .dt_addr(dt_addr), .dt_base(dt_base),
        .dt_limit(dt_limit), .dt_type(dt_type),
        .out_valid(out_valid), .out_fault(out_fault), .out_addr(out_addr)
    );

    function automatic logic [OW-1:0] exp_offset(logic be, logic [OW-1:0] b,
            logic ie, logic [OW-1:0] i, logic [1:0] sc, logic de, logic [OW-1:0] d);
        logic [OW-1:0] s;
        s = 0;
        if (be) s = s + b;
        if (ie) s = s + i * (OW'(1) << sc);
        if (de) s = s + d;
        return s;
    endfunction

    function automatic logic [BW+1:0] exp_result(logic wr, logic [OW-1:0] ofs, int sel);
        logic flt;
        flt = (ofs > sh_lim[sel]) || !sh_type[sel][0] || (wr && !sh_type[sel][1]);
        if (flt) return {1'b0, 1'b1, {BW{1'b0}}};
        return {1'b1, 1'b0, sh_base[sel] + BW'(ofs)};
    endfunction

    task automatic check(string req, logic [BW+1:0] act, logic [BW+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got v=%b f=%b a=%h, expected v=%b f=%b a=%h", req,
                act[BW+1], act[BW], act[BW-1:0], exp[BW+1], exp[BW], exp[BW-1:0]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic access(string req, logic wr, logic be, logic [OW-1:0] b,
            logic ie, logic [OW-1:0] i, logic [1:0] sc, logic de, logic [OW-1:0] d,
            int sel, logic we, int wa, logic [BW-1:0] wb, logic [OW-1:0] wl, logic [1:0] wt);
        logic [BW+1:0] e;
        e = exp_result(wr, exp_offset(be, b, ie, i, sc, de, d), sel);
        req_valid = 1; req_write = wr; base_en = be; base_val = b; idx_en = ie;
        idx_val = i; idx_scale = sc; disp_en = de; disp_val = d; seg_sel = SW'(sel);
        dt_we = we; dt_addr = SW'(wa); dt_base = wb; dt_limit = wl; dt_type = wt;
        @(posedge clk);
        #1;
        check(req, {out_valid, out_fault, out_addr}, e);
        if (we) begin sh_base[wa] = wb; sh_lim[wa] = wl; sh_type[wa] = wt; end
        @(negedge clk);
        req_valid = 0; dt_we = 0;
    endtask

    task automatic req(string r, logic wr, logic be, logic [OW-1:0] b, logic ie,
            logic [OW-1:0] i, logic [1:0] sc, logic de, logic [OW-1:0] d, int sel);
        access(r, wr, be, b, ie, i, sc, de, d, sel, 0, 0, '0, '0, '0);
    endtask

    task automatic wr_desc(int wa, logic [BW-1:0] wb, logic [OW-1:0] wl, logic [1:0] wt);
        dt_we = 1; dt_addr = SW'(wa); dt_base = wb; dt_limit = wl; dt_type = wt;
        @(posedge clk);
        #1;
        sh_base[wa] = wb; sh_lim[wa] = wl; sh_type[wa] = wt;
        @(negedge clk);
        dt_we = 0;
    endtask

    task automatic idle_check(string r);
        @(posedge clk);
        #1;
        check(r, {out_valid, out_fault, out_addr}, '0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        for (int k = 0; k < NSEG; k++) begin
            sh_base[k] = '0; sh_lim[k] = '1; sh_type[k] = 2'b11;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R10 outputs in reset", {out_valid, out_fault, out_addr}, '0);
        rst_n = 1;
        @(negedge clk);

        // R10: reset descriptors are base 0, limit max, present+writable
        req("R10 default read max offset", 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5);
        req("R10 default write", 1, 1, 32'h0000_1234, 0, 0, 0, 0, 0, 2);

        wr_desc(1, 32'h1000_0000, 32'h0000_FFFF, 2'b11);
        req("R5 offset equals limit", 0, 1, 32'h0000_FFF0, 0, 0, 0, 1, 32'hF, 1);
        req("R5 offset above limit", 0, 1, 32'h0000_FFF0, 0, 0, 0, 1, 32'h10, 1);
        req("R9 fault clears address", 0, 0, 0, 1, 32'h0002_0000, 0, 0, 0, 1);
        req("R2 scale x8", 0, 1, 32'h10, 1, 32'h100, 2'd3, 0, 0, 1);
        req("R2 scale x2", 0, 0, 0, 1, 32'h300, 2'd1, 1, 32'h4, 1);
        req("R2 scale x4", 0, 1, 32'h1, 1, 32'h40, 2'd2, 1, 32'h2, 1);
        req("R1 disabled terms ignored", 0, 1, 32'h20, 0, 32'hFFFF, 2'd3, 0, 32'hFFFF, 1);
        req("R3 offset wraps", 0, 1, 32'hFFFF_FFF0, 0, 0, 0, 1, 32'h20, 0);
        req("R3 scaled index wraps", 0, 0, 0, 1, 32'h2000_0001, 2'd3, 0, 0, 0);

        wr_desc(2, 32'hFFFF_FF00, 32'hFFFF_FFFF, 2'b11);
        req("R4 linear wraps", 0, 1, 32'h200, 0, 0, 0, 0, 0, 2);

        wr_desc(3, 32'h0000_4000, 32'hFFFF_FFFF, 2'b10);
        req("R6 not present read", 0, 1, 32'h4, 0, 0, 0, 0, 0, 3);
        req("R6 not present write", 1, 1, 32'h4, 0, 0, 0, 0, 0, 3);

        wr_desc(4, 32'h0000_8000, 32'hFFFF_FFFF, 2'b01);
        req("R7 read only segment read", 0, 1, 32'h8, 0, 0, 0, 0, 0, 4);
        req("R7 read only segment write", 1, 1, 32'h8, 0, 0, 0, 0, 0, 4);
        idle_check("R8 idle cycle quiet");

        // R11: same-cycle write is not seen, next cycle it is
        access("R11 same-cycle write uses old", 0, 1, 32'h44, 0, 0, 0, 0, 0, 6,
               1, 6, 32'h0005_0000, 32'hFFFF_FFFF, 2'b11);
        req("R11 write seen next cycle", 0, 1, 32'h44, 0, 0, 0, 0, 0, 6);

        // R8: back-to-back randomized requests, R1 offset model
        for (int n = 0; n < 600; n++) begin
            if (n % 16 == 0) begin
                wr_desc(int'($urandom % NSEG), $urandom, $urandom & 32'h0003_FFFF,
                        2'($urandom));
            end
            req("R1 random request", 1'($urandom), 1'($urandom), $urandom & 32'h0001_FFFF,
                1'($urandom), $urandom & 32'h0000_3FFF, 2'($urandom), 1'($urandom),
                (n % 7 == 0) ? $urandom : ($urandom & 32'h0000_FFFF), int'($urandom % NSEG));
        end
        idle_check("R8 idle after burst");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule